// File: doc/BRIEF.md
# Two-Wire Control Register Slave for a Sound Processor

This block is the control front end of an audio signal chain. It listens on a two-wire serial bus as a slave and keeps a small bank of byte-wide settings: source selection and mute mode, input gain, volume, loudness, tone, and one attenuator per output. The rest of the chip reads these settings as decoded fields. The bus clock and data lines are oversampled by the system clock. Each line passes through a synchroniser and an edge detector, so the block needs no clock of its own from the bus.

A bus master writes by sending a start condition and the 7-bit device address with the direction bit set to 1. It then sends a register index (the subaddress) followed by any number of data bytes, and ends with a stop condition. Each data byte goes to the current index, and the index then moves on by one. This lets one transfer fill several neighbouring registers.

With the direction bit at 0, the block instead returns a status byte. The byte carries two sticky overload flags (one for the input gain stage, one for the tone stage) and the current state of the zero-cross mute sequencer. The data line is only ever pulled low, never driven high.

Top module: `sndctl_i2c_regs`

## Requirements
- R1: After reset every register is zero, so every decoded control output is zero, and the data line is released (sda_pull_o = 0).
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 1000011). For any other address it pulls the data line on no bit of the transfer and changes no register.
- R3: The least significant bit of the address byte picks the direction: 1 starts a write transfer and 0 starts a read transfer.
- R4: In a write, the first byte after the address is the subaddress. Each later byte is stored in the register at the current subaddress, after which the subaddress goes up by one (it stays at 255 once there). Every byte is acknowledged.
- R5: Data bytes aimed at a subaddress above 8 are acknowledged, and they change no register.
- R6: Register 0 decodes as follows: bit 0 selects the first source (src_cd_o), bit 1 the second (src_aux2_o), bit 2 the third (src_aux3_o), bit 3 bridge drive (bridge_o), bit 4 raised output drive (fanout_o), bit 5 instant mute (mute_now_o) and bit 6 zero-cross mute (mute_zc_o).
- R7: Register 1 bits 3..0 are the input gain code. Codes 0 to 10 pass through unchanged on in_gain_o, and codes 11 to 15 all appear as 10.
- R8: vol_o shows register 2 bits 5..0. loud_en_o shows register 3 bit 6 and loud_lvl_o shows register 3 bits 5..0. att_o[4k+3:4k] shows bits 3..0 of register 5+k: k=0 rear left, k=1 front left, k=2 rear right, k=3 front right.
- R9: For register 4, treble_o shows bits 7..4 and bass_o shows bits 3..0 (0000 is most boost, 1000 flat, 1111 most cut).
- R10: Each byte of a read transfer reads as follows: bit 7 is the input-stage overload flag, bit 6 is zc_done_i, bit 0 is the tone-stage overload flag, and bits 5..1 are zero. When the master acknowledges a byte, another status byte follows.
- R11: A high cycle on clip_level_i or clip_tone_i sets its flag, and the flag stays set until a status byte is loaded for sending. That load clears the flag, unless the same input is high in that cycle. Write transfers do not clear the flags.
- R12: A stop condition ends any transfer at once and releases the data line. A partly received data byte is then dropped. A start condition, including a repeated start inside a transfer, begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| clip_level_i | input | 1 | Overload seen in the input gain stage |
| clip_tone_i | input | 1 | Overload seen in the tone stage |
| zc_done_i | input | 1 | Zero-cross mute sequencer has completed |
| src_cd_o | output | 1 | Select first source |
| src_aux2_o | output | 1 | Select second source |
| src_aux3_o | output | 1 | Select third source |
| bridge_o | output | 1 | Invert one output per side for bridge drive |
| fanout_o | output | 1 | Raised output drive strength |
| mute_now_o | output | 1 | Instant mute request |
| mute_zc_o | output | 1 | Mute at next zero crossing request |
| in_gain_o | output | 4 | Input gain code, limited to LEVEL_MAX |
| vol_o | output | 6 | Volume attenuator code |
| loud_en_o | output | 1 | Loudness enable |
| loud_lvl_o | output | 6 | Loudness attenuator code |
| treble_o | output | 4 | Treble code |
| bass_o | output | 4 | Bass code |
| att_o | output | 16 | Four output attenuator codes, 4 bits each |

## Verification
The bench checks a burst that runs past subaddress 8. A design that stored the overflow bytes anywhere, or that failed to acknowledge them, would corrupt an attenuator or stall the master. It writes gain codes on both sides of the limit, where a missing clamp shows 15 instead of 10. It reads status twice in one transfer: a flag that never cleared, or one cleared before its byte was sampled, would show the wrong bit 7 or bit 0. It also sends a foreign address, a stop in the middle of a byte and a repeated start. A design that answered the wrong address, or stored a partial byte, would show a changed register afterwards.

// File: rtl/sndctl_pkg.sv
package sndctl_pkg;

   localparam int BYTE_W   = 8;
   localparam int CNT_W    = $clog2(BYTE_W + 1);
   localparam int GAIN_W   = 4;
   localparam int VOL_W    = 6;
   localparam int TONE_W   = 4;
   localparam int ATT_W    = 4;

   // register indices whose order the bus master relies on
   localparam int SUB_SWITCH = 0;
   localparam int SUB_LEVEL  = 1;
   localparam int SUB_VOLUME = 2;
   localparam int SUB_LOUD   = 3;
   localparam int SUB_TONE   = 4;
   localparam int SUB_ATT0   = 5;

   // register 0 bit positions
   localparam int SW_CD     = 0;
   localparam int SW_AUX2   = 1;
   localparam int SW_AUX3   = 2;
   localparam int SW_BRIDGE = 3;
   localparam int SW_FAN    = 4;
   localparam int SW_MNOW   = 5;
   localparam int SW_MZC    = 6;

   localparam int LOUD_EN_BIT = 6;

   // status byte bit positions
   localparam int ST_CLIP_LEVEL = 7;
   localparam int ST_ZC_DONE    = 6;
   localparam int ST_CLIP_TONE  = 0;

   typedef enum logic [3:0] {
      BUS_IDLE,
      BUS_ADDR,
      BUS_ADDR_ACK,
      BUS_SUB,
      BUS_SUB_ACK,
      BUS_DATA,
      BUS_DATA_ACK,
      BUS_TX,
      BUS_TX_ACK
   } bus_state_t;

endpackage

// File: rtl/sndctl_pin_sync.sv
module sndctl_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sndctl_pin_sync: STAGES must be at least 2");
   end

   // stage STAGES holds the previous synchronised value for edge detection
   logic [STAGES:0] chain;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b1;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
   assign fall_o  = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/sndctl_i2c_fsm.sv
module sndctl_i2c_fsm
   import sndctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h43
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              rd_load,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_pull
);

   localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(BYTE_W);
   localparam logic [BYTE_W-1:0] PTR_TOP  = {BYTE_W{1'b1}};

   bus_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [BYTE_W-1:0] ptr;
   logic              is_write;
   logic              mack;
   logic              start_det, stop_det, byte_done;

   assign start_det = sda_fall & scl_lvl;
   assign stop_det  = sda_rise & scl_lvl;
   assign byte_done = scl_fall & (cnt == FULL_CNT);

   always_comb begin
      rd_load = 1'b0;
      if (!start_det && !stop_det && scl_fall) begin
         if (state == BUS_ADDR_ACK && !is_write) rd_load = 1'b1;
         if (state == BUS_TX_ACK && mack)        rd_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= BUS_IDLE;
         cnt      <= '0;
         sh       <= '0;
         tx       <= '0;
         ptr      <= '0;
         is_write <= 1'b0;
         mack     <= 1'b0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state    <= BUS_IDLE;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            state    <= BUS_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               BUS_ADDR, BUS_SUB, BUS_DATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (byte_done) begin
                     cnt <= '0;
                     if (state == BUS_ADDR) begin
                        if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                           is_write <= sh[0];
                           sda_pull <= 1'b1;
                           state    <= BUS_ADDR_ACK;
                        end else begin
                           state <= BUS_IDLE;
                        end
                     end else if (state == BUS_SUB) begin
                        ptr      <= sh;
                        sda_pull <= 1'b1;
                        state    <= BUS_SUB_ACK;
                     end else begin
                        wr_en    <= 1'b1;
                        wr_addr  <= ptr;
                        wr_data  <= sh;
                        ptr      <= (ptr == PTR_TOP) ? ptr : ptr + 1'b1;
                        sda_pull <= 1'b1;
                        state    <= BUS_DATA_ACK;
                     end
                  end
               end
               BUS_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (is_write) begin
                        sda_pull <= 1'b0;
                        state    <= BUS_SUB;
                     end else begin
                        tx       <= rd_byte;
                        sda_pull <= ~rd_byte[BYTE_W-1];
                        state    <= BUS_TX;
                     end
                  end
               end
               BUS_SUB_ACK, BUS_DATA_ACK: begin
                  if (scl_fall) begin
                     cnt      <= '0;
                     sda_pull <= 1'b0;
                     state    <= BUS_DATA;
                  end
               end
               BUS_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (byte_done) begin
                     sda_pull <= 1'b0;
                     state    <= BUS_TX_ACK;
                  end else if (scl_fall) begin
                     tx       <= {tx[BYTE_W-2:0], 1'b0};
                     sda_pull <= ~tx[BYTE_W-2];
                  end
               end
               BUS_TX_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx       <= rd_byte;
                        sda_pull <= ~rd_byte[BYTE_W-1];
                        cnt      <= '0;
                        state    <= BUS_TX;
                     end else begin
                        state <= BUS_IDLE;
                     end
                  end
               end
               default: state <= BUS_IDLE;
            endcase
         end
      end
   end

   logic unused_tx_msb;
   assign unused_tx_msb = tx[BYTE_W-1];

   // R2: an unaddressed or finished slave never holds the line
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BUS_IDLE) |-> !sda_pull);

   // R12: a stop always frees the data line
   p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_pull && state == BUS_IDLE));

   // R4: one store per received data byte
   p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/sndctl_regfile.sv
module sndctl_regfile
   import sndctl_pkg::*;
#(
   parameter int NUM_ATT     = 4,
   parameter int LEVEL_MAX   = 10,
   parameter bit STICKY_CLIP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [BYTE_W-1:0]        wr_addr,
   input  logic [BYTE_W-1:0]        wr_data,
   input  logic                     rd_load,
   input  logic                     clip_level_i,
   input  logic                     clip_tone_i,
   input  logic                     zc_done_i,
   output logic [BYTE_W-1:0]        rd_byte,
   output logic                     src_cd_o,
   output logic                     src_aux2_o,
   output logic                     src_aux3_o,
   output logic                     bridge_o,
   output logic                     fanout_o,
   output logic                     mute_now_o,
   output logic                     mute_zc_o,
   output logic [GAIN_W-1:0]        in_gain_o,
   output logic [VOL_W-1:0]         vol_o,
   output logic                     loud_en_o,
   output logic [VOL_W-1:0]         loud_lvl_o,
   output logic [TONE_W-1:0]        treble_o,
   output logic [TONE_W-1:0]        bass_o,
   output logic [NUM_ATT*ATT_W-1:0] att_o
);

   localparam int NUM_REGS = SUB_ATT0 + NUM_ATT;
   localparam logic [GAIN_W-1:0] GAIN_CAP = GAIN_W'(LEVEL_MAX);

   logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_addr == BYTE_W'(i)) regs[i] <= wr_data;
         end
      end
   end

   assign src_cd_o   = regs[SUB_SWITCH][SW_CD];
   assign src_aux2_o = regs[SUB_SWITCH][SW_AUX2];
   assign src_aux3_o = regs[SUB_SWITCH][SW_AUX3];
   assign bridge_o   = regs[SUB_SWITCH][SW_BRIDGE];
   assign fanout_o   = regs[SUB_SWITCH][SW_FAN];
   assign mute_now_o = regs[SUB_SWITCH][SW_MNOW];
   assign mute_zc_o  = regs[SUB_SWITCH][SW_MZC];

   assign in_gain_o  = (regs[SUB_LEVEL][GAIN_W-1:0] > GAIN_CAP) ?
                       GAIN_CAP : regs[SUB_LEVEL][GAIN_W-1:0];
   assign vol_o      = regs[SUB_VOLUME][VOL_W-1:0];
   assign loud_en_o  = regs[SUB_LOUD][LOUD_EN_BIT];
   assign loud_lvl_o = regs[SUB_LOUD][VOL_W-1:0];
   assign treble_o   = regs[SUB_TONE][BYTE_W-1 -: TONE_W];
   assign bass_o     = regs[SUB_TONE][TONE_W-1:0];

   for (genvar a = 0; a < NUM_ATT; a++) begin : g_att
      assign att_o[a*ATT_W +: ATT_W] = regs[SUB_ATT0+a][ATT_W-1:0];
   end

   logic unused_reg_bits;
   assign unused_reg_bits = ^regs;

   logic flag_level, flag_tone;

   if (STICKY_CLIP) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_level <= 1'b0;
            flag_tone  <= 1'b0;
         end else begin
            flag_level <= clip_level_i | (flag_level & ~rd_load);
            flag_tone  <= clip_tone_i  | (flag_tone  & ~rd_load);
         end
      end

      // R11: an overload pulse is never lost
      p_clip_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
         clip_level_i |=> flag_level);

      // R11: only a status load may clear a flag
      p_clip_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_tone && !rd_load) |=> flag_tone);
   end else begin : g_live
      logic unused_rd_load;
      assign unused_rd_load = rd_load;
      assign flag_level = clip_level_i;
      assign flag_tone  = clip_tone_i;
   end

   always_comb begin
      rd_byte                = '0;
      rd_byte[ST_CLIP_LEVEL] = flag_level;
      rd_byte[ST_ZC_DONE]    = zc_done_i;
      rd_byte[ST_CLIP_TONE]  = flag_tone;
   end

   // R5: stores beyond the bank leave every register alone
   p_ignore_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= BYTE_W'(NUM_REGS)) |=> $stable(regs));

   // R7: the decoded gain never exceeds the top step
   p_gain_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_gain_o <= GAIN_CAP);

endmodule

// File: rtl/sndctl_i2c_regs.sv
module sndctl_i2c_regs
   import sndctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1000011,
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_ATT     = 4,
   parameter int         LEVEL_MAX   = 10,
   parameter bit         STICKY_CLIP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   output logic                     sda_pull_o,
   input  logic                     clip_level_i,
   input  logic                     clip_tone_i,
   input  logic                     zc_done_i,
   output logic                     src_cd_o,
   output logic                     src_aux2_o,
   output logic                     src_aux3_o,
   output logic                     bridge_o,
   output logic                     fanout_o,
   output logic                     mute_now_o,
   output logic                     mute_zc_o,
   output logic [GAIN_W-1:0]        in_gain_o,
   output logic [VOL_W-1:0]         vol_o,
   output logic                     loud_en_o,
   output logic [VOL_W-1:0]         loud_lvl_o,
   output logic [TONE_W-1:0]        treble_o,
   output logic [TONE_W-1:0]        bass_o,
   output logic [NUM_ATT*ATT_W-1:0] att_o
);

   if (NUM_ATT < 1 || SUB_ATT0 + NUM_ATT > (1 << BYTE_W)) begin : g_bad_att
      $error("sndctl_i2c_regs: NUM_ATT out of range");
   end
   if (LEVEL_MAX < 0 || LEVEL_MAX >= (1 << GAIN_W)) begin : g_bad_level
      $error("sndctl_i2c_regs: LEVEL_MAX does not fit the gain field");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic wr_en, rd_load;
   logic [BYTE_W-1:0] wr_addr, wr_data, rd_byte;

   sndctl_pin_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   sndctl_pin_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   sndctl_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .rd_byte(rd_byte), .rd_load(rd_load),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sda_pull(sda_pull_o));

   sndctl_regfile #(
      .NUM_ATT(NUM_ATT), .LEVEL_MAX(LEVEL_MAX), .STICKY_CLIP(STICKY_CLIP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_load(rd_load),
      .clip_level_i(clip_level_i), .clip_tone_i(clip_tone_i),
      .zc_done_i(zc_done_i), .rd_byte(rd_byte),
      .src_cd_o(src_cd_o), .src_aux2_o(src_aux2_o), .src_aux3_o(src_aux3_o),
      .bridge_o(bridge_o), .fanout_o(fanout_o),
      .mute_now_o(mute_now_o), .mute_zc_o(mute_zc_o),
      .in_gain_o(in_gain_o), .vol_o(vol_o),
      .loud_en_o(loud_en_o), .loud_lvl_o(loud_lvl_o),
      .treble_o(treble_o), .bass_o(bass_o), .att_o(att_o));

endmodule

// File: tb/sndctl_i2c_regs_bench.sv
`timescale 1ns/1ps
module sndctl_i2c_regs_bench;

   localparam int Q = 25;
   localparam logic [6:0] DEV = 7'b1000011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic m_scl = 1'b1, m_low = 1'b0;
   logic clip_l = 1'b0, clip_t = 1'b0, zc = 1'b0;
   logic sda_pull, sda_line;
   logic src_cd, src_a2, src_a3, bridge, fanout, mnow, mzc, loud_en;
   logic [3:0] in_gain, treble, bass;
   logic [5:0] vol, loud_lvl;
   logic [15:0] att;

   assign sda_line = ~(m_low | sda_pull);

   sndctl_i2c_regs u_sndctl_i2c_regs (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .clip_level_i(clip_l), .clip_tone_i(clip_t),
      .zc_done_i(zc), .src_cd_o(src_cd), .src_aux2_o(src_a2),
      .src_aux3_o(src_a3), .bridge_o(bridge), .fanout_o(fanout),
      .mute_now_o(mnow), .mute_zc_o(mzc), .in_gain_o(in_gain), .vol_o(vol),
      .loud_en_o(loud_en), .loud_lvl_o(loud_lvl), .treble_o(treble),
      .bass_o(bass), .att_o(att));

   int tests = 0, fails = 0;
   logic [7:0] exp_reg [9];
   logic e_c1 = 1'b0, e_c2 = 1'b0;
   logic cmp_en = 1'b0;
   logic done = 1'b0;
   logic [7:0] wq[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] e_gain();
      return (exp_reg[1][3:0] > 4'd10) ? 4'd10 : exp_reg[1][3:0];
   endfunction

   // cycle-by-cycle comparison against the model whenever the bus is quiet
   always @(negedge clk) begin
      if (cmp_en) begin
         chk({mzc, mnow, fanout, bridge, src_a3, src_a2, src_cd} == exp_reg[0][6:0],
             "R6 switch fields", {mzc, mnow, fanout, bridge, src_a3, src_a2, src_cd},
             exp_reg[0][6:0]);
         chk(in_gain == e_gain(), "R7 gain", in_gain, e_gain());
         chk({vol, loud_en, loud_lvl} == {exp_reg[2][5:0], exp_reg[3][6], exp_reg[3][5:0]},
             "R8 volume/loudness", {vol, loud_en, loud_lvl},
             {exp_reg[2][5:0], exp_reg[3][6], exp_reg[3][5:0]});
         chk({treble, bass} == exp_reg[4], "R9 tone", {treble, bass}, exp_reg[4]);
         chk(att == {exp_reg[8][3:0], exp_reg[7][3:0], exp_reg[6][3:0], exp_reg[5][3:0]},
             "R8 attenuators", att,
             {exp_reg[8][3:0], exp_reg[7][3:0], exp_reg[6][3:0], exp_reg[5][3:0]});
         chk(!sda_pull, "R12 line released when idle", sda_pull, 0);
      end
   end

   task automatic wq_(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; wq_(Q);
      m_scl = 1'b1; wq_(Q);
      m_low = 1'b1; wq_(Q);
      m_scl = 1'b0; wq_(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq_(Q);
      m_scl = 1'b1; wq_(Q);
      m_low = 1'b0; wq_(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_low = ~b[i]; wq_(Q);
         m_scl = 1'b1; wq_(Q);
         m_scl = 1'b0; wq_(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_low = 1'b0; wq_(Q);
      m_scl = 1'b1; wq_(Q / 2);
      ack = ~sda_line;
      wq_(Q - Q / 2);
      m_scl = 1'b0; wq_(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic give_ack);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wq_(Q);
         m_scl = 1'b1; wq_(Q / 2);
         b[i] = sda_line;
         wq_(Q - Q / 2);
         m_scl = 1'b0;
      end
      m_low = give_ack; wq_(Q);
      m_scl = 1'b1; wq_(Q);
      m_scl = 1'b0; wq_(Q);
      m_low = 1'b0;
   endtask

   task automatic settle();
      wq_(10);
      cmp_en = 1'b1;
      wq_(20);
   endtask

   // write transfer: address a, subaddress sub, data from wq
   task automatic write_txn(input logic [6:0] a, input logic [7:0] sub);
      logic ack;
      int ptr;
      bit hit;
      hit = (a == DEV);
      cmp_en = 1'b0;
      bus_start();
      send_byte({a, 1'b1}, ack);
      chk(ack == hit, "R2/R3 address acknowledge", ack, hit);
      send_byte(sub, ack);
      chk(ack == hit, "R4 subaddress acknowledge", ack, hit);
      ptr = sub;
      foreach (wq[k]) begin
         send_byte(wq[k], ack);
         chk(ack == hit, (ptr > 8) ? "R5 acknowledge above bank" : "R4 data acknowledge",
             ack, hit);
         if (hit && ptr <= 8) exp_reg[ptr] = wq[k];
         if (ptr < 255) ptr++;
      end
      bus_stop();
      wq.delete();
      settle();
   endtask

   task automatic read_txn(input int n);
      logic ack;
      logic [7:0] b, e;
      cmp_en = 1'b0;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk(ack, "R3 read address acknowledge", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(b, k < n - 1);
         e = {e_c1, zc, 5'b0, e_c2};
         e_c1 = 1'b0; e_c2 = 1'b0;
         chk(b == e, (k == 0) ? "R10/R11 status byte" : "R10/R11 repeated status byte",
             b, e);
      end
      bus_stop();
      settle();
   endtask

   task automatic pulse_clip(input bit lvl, input bit tone);
      clip_l = lvl; clip_t = tone;
      wq_(2);
      clip_l = 1'b0; clip_t = 1'b0;
      if (lvl)  e_c1 = 1'b1;
      if (tone) e_c2 = 1'b1;
      wq_(4);
   endtask

   initial begin
      logic ack;
      for (int i = 0; i < 9; i++) exp_reg[i] = 8'h00;
      wq_(6);
      rst_n = 1'b1;
      wq_(6);
      // R1: reset state
      chk({src_cd, src_a2, src_a3, bridge, fanout, mnow, mzc, loud_en} == 8'h0,
          "R1 reset switch/loudness", {src_cd, src_a2, src_a3, bridge, fanout, mnow, mzc, loud_en}, 0);
      chk({in_gain, vol, loud_lvl, treble, bass, att} == '0, "R1 reset fields",
          {in_gain, vol, loud_lvl, treble, bass}, 0);
      chk(!sda_pull, "R1 reset line released", sda_pull, 0);
      cmp_en = 1'b1;
      wq_(20);

      // R6 single write to the switch register
      wq.push_back(8'h55); write_txn(DEV, 8'd0);
      // R4 burst over level, volume, loudness, tone; R7 code 13 capped
      wq.push_back(8'h0D); wq.push_back(8'h2A); wq.push_back(8'h5B); wq.push_back(8'h3C);
      write_txn(DEV, 8'd1);
      // R5 burst running past the last attenuator
      wq.push_back(8'h01); wq.push_back(8'h02); wq.push_back(8'h03); wq.push_back(8'h0F);
      wq.push_back(8'hAA); wq.push_back(8'hBB);
      write_txn(DEV, 8'd5);
      // R5 direct write above the bank
      wq.push_back(8'hFF); write_txn(DEV, 8'd9);
      // R2 foreign address changes nothing
      wq.push_back(8'h00); write_txn(7'b1000010, 8'd0);
      // R7 gain codes around the cap
      wq.push_back(8'h07); write_txn(DEV, 8'd1);
      wq.push_back(8'h0A); write_txn(DEV, 8'd1);
      wq.push_back(8'hFF); write_txn(DEV, 8'd1);
      // R8 loudness off with full level, volume top code
      wq.push_back(8'h3F); wq.push_back(8'hBF); write_txn(DEV, 8'd2);

      // R10 plain status with zero-cross done
      zc = 1'b1; wq_(5);
      read_txn(1);
      // R11 both flags, then cleared in the repeated byte
      zc = 1'b0;
      pulse_clip(1'b1, 1'b1);
      read_txn(2);
      // R11 a write transfer leaves the flag standing
      pulse_clip(1'b0, 1'b1);
      wq.push_back(8'h09); write_txn(DEV, 8'd6);
      read_txn(1);

      // R12 stop in the middle of a data byte drops it
      cmp_en = 1'b0;
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      send_byte(8'd2, ack);
      send_bits(8'h00, 4);
      m_scl = 1'b1; m_low = 1'b1; wq_(Q);
      m_low = 1'b0; wq_(Q);
      settle();
      // R12 repeated start begins a fresh address phase
      cmp_en = 1'b0;
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      send_byte(8'd3, ack);
      m_low = 1'b0; wq_(Q);
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk(ack, "R12 address after repeated start", ack, 1);
      send_byte(8'd6, ack);
      send_byte(8'h07, ack);
      chk(ack, "R12 data after repeated start", ack, 1);
      exp_reg[6] = 8'h07;
      bus_stop();
      settle();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule